// File: doc/BRIEF.md
# I2C bus condition monitor

The monitor listens passively to the two lines of an I2C bus and turns what it sees into status a processor can use. Both lines are brought into the system clock domain through a two-flop synchronizer and then a glitch filter. A filtered line changes only once its synchronized value has disagreed with it for `FILT_LEN` system clocks in a row. From the filtered lines the block picks out the two framing conditions. A falling SDA while SCL stays high is a START. A rising SDA while SCL stays high is a STOP. SDA changes while SCL is low are ordinary data and are ignored.

Each condition sets its own sticky raw status bit. A busy flag is set by START and cleared by STOP. A two-bit mask selects which raw bits feed a single interrupt line. A small register port exposes the status, a write-one-to-clear location and the mask. The block never drives the bus.

Top module: `i2c_cond_mon`

## Requirements
- R1: After reset the busy flag is 0, both raw status bits are 0, the mask is 0 and `irq_o` is 0.
- R2: SDA falling while SCL is high sets raw START (raw register bit 0) and sets busy (raw register bit 2, also `busy_o`). A repeated START while busy sets raw START again.
- R3: SDA rising while SCL is high sets raw STOP (raw register bit 1) and clears busy. A STOP while not busy still sets raw STOP.
- R4: An SDA change while SCL is low sets no status bit and leaves busy unchanged. SCL rising or falling while SDA is steady also flags nothing.
- R5: Raw status bits stay set until a write to address 2 with a 1 in the matching bit (bit 0 START, bit 1 STOP). Bits written 0 have no effect.
- R6: The masked status at address 1 reads raw AND mask in bits 1:0. `irq_o` is the OR of those masked bits.
- R7: The mask is written and read at address 3, bits 1:0 (bit 0 START, bit 1 STOP). Address 0 reads {busy, raw STOP, raw START} in bits 2:0. Unused read bits are 0.
- R8: A line pulse that lasts fewer than `FILT_LEN` system clocks after synchronization is filtered out and flags no condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed I2C clock line |
| sda_i | input | 1 | Sensed I2C data line |
| reg_addr_i | input | 2 | Register address: 0 raw, 1 masked, 2 clear, 3 mask |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational from address |
| busy_o | output | 1 | Bus busy flag |
| irq_o | output | 1 | Combined interrupt, OR of masked status |

## Verification
The assertions assume the filtered lines change one at a time. A condition is only recognised on a clock where SCL was high both before and after the SDA edge. The stimulus therefore changes one line per step and holds each level well beyond the synchronizer and filter latency, so every edge is seen separately. The one exception is the glitch test, which holds SDA low for deliberately fewer clocks than the filter length while SCL stays high.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int unsigned NUM_EVT = 2;
  localparam int unsigned EVT_START = 0;
  localparam int unsigned EVT_STOP  = 1;

  typedef enum logic [1:0] {
    ADDR_RAW  = 2'd0,
    ADDR_MSK  = 2'd1,
    ADDR_CLR  = 2'd2,
    ADDR_MASK = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_w;
  logic                   filt_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end
  assign sync_w = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sync_w == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_MAX) begin
      filt_q <= sync_w;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign line_o = filt_q;

  // R8
  filt_follows_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(sync_w) == filt_q));
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic busy_o
);
  logic scl_q, sda_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SCL must be high on both sides of the SDA edge
  assign start_o = scl_q & scl_i &  sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q &  sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (start_o) busy_q <= 1'b1;
    else if (stop_o)  busy_q <= 1'b0;
  end
  assign busy_o = busy_q;

  // R2
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_q);
  // R3
  stop_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !busy_q);
  // R4
  data_change_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_i && (sda_i != sda_q)) |-> (!start_o && !stop_o));
  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_o && !stop_o) |=> $stable(busy_q));
endmodule

// File: rtl/i2c_status_regs.sv
module i2c_status_regs
  import i2c_mon_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               busy_i,
  input  logic [1:0]         reg_addr_i,
  input  logic               reg_we_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] raw_q, mask_q, clr_w, msk_w;

  assign clr_w = (reg_we_i && reg_addr_i == ADDR_CLR) ? reg_wdata_i[NUM_EVT-1:0] : '0;

  // new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_w) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   mask_q <= '0;
    else if (reg_we_i && reg_addr_i == ADDR_MASK)  mask_q <= reg_wdata_i[NUM_EVT-1:0];
  end

  assign msk_w = raw_q & mask_q;
  assign irq_o = |msk_w;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_RAW:  reg_rdata_o[NUM_EVT:0]   = {busy_i, raw_q};
      ADDR_MSK:  reg_rdata_o[NUM_EVT-1:0] = msk_w;
      ADDR_MASK: reg_rdata_o[NUM_EVT-1:0] = mask_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    // R2 R3
    evt_sets_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> raw_q[g]);
    // R5
    raw_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_q[g] && !clr_w[g]) |=> raw_q[g]);
  end

  // R6
  no_mask_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon
  import i2c_mon_pkg::*;
#(
  parameter int unsigned FILT_LEN    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DW          = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          busy_o,
  output logic          irq_o
);
  logic [1:0]         line_raw, line_flt;
  logic [NUM_EVT-1:0] evt;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(line_raw[g]),
      .line_o(line_flt[g])
    );
  end

  i2c_cond_detect i_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (line_flt[1]),
    .sda_i  (line_flt[0]),
    .start_o(evt[EVT_START]),
    .stop_o (evt[EVT_STOP]),
    .busy_o (busy_o)
  );

  i2c_status_regs #(.DW(DW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .busy_i     (busy_o),
    .reg_addr_i (reg_addr_i),
    .reg_we_i   (reg_we_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!busy_o && !irq_o));
endmodule

// File: tb/test_i2c_cond_mon.sv
module test_i2c_cond_mon;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy, irq;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_mon i_i2c_cond_mon (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .busy_o(busy), .irq_o(irq)
  );

  // {scl, sda, exp busy, exp raw stop, exp raw start}
  localparam logic [4:0] VEC [20] = '{
    5'b10_101, // R2 start
    5'b00_100, // R4 scl falls
    5'b01_100, // R4 data change scl low
    5'b11_100, // R4 scl rises
    5'b01_100,
    5'b00_100, // R4
    5'b10_100,
    5'b11_010, // R3 stop
    5'b10_101, // R2
    5'b11_010, // R3
    5'b01_000, // R4 not busy
    5'b00_000,
    5'b10_000,
    5'b11_010, // R3 stop while idle
    5'b10_101, // R2
    5'b00_100,
    5'b01_100,
    5'b11_100,
    5'b10_101, // R2 repeated start
    5'b11_010  // R3
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic drive(input logic c, input logic d, input int n);
    @(negedge clk);
    scl = c; sda = d;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(2'd0, d); check("R1 raw", d, 8'h00);
    rd(2'd3, d); check("R1 mask", d, 8'h00);
    rd(2'd1, d); check("R1 masked", d, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    for (int i = 0; i < 20; i++) begin
      drive(VEC[i][4], VEC[i][3], HOLD);
      rd(2'd0, d);
      check($sformatf("R2/R3/R4 vec%0d", i), d, {5'd0, VEC[i][2:0]});
      check($sformatf("R2/R3 busy_o vec%0d", i), {7'd0, busy}, {7'd0, VEC[i][2]});
      wr(2'd2, 8'h03);
    end

    // R5 sticky, partial clear
    drive(1, 0, HOLD); drive(1, 1, HOLD);
    repeat (10) @(negedge clk);
    rd(2'd0, d); check("R5 both sticky", d, 8'h03);
    wr(2'd2, 8'h01);
    rd(2'd0, d); check("R5 clear start only", d, 8'h02);
    wr(2'd2, 8'h00);
    rd(2'd0, d); check("R5 zero write no effect", d, 8'h02);
    wr(2'd2, 8'h02);
    rd(2'd0, d); check("R5 clear stop", d, 8'h00);

    // R7 mask readback
    wr(2'd3, 8'hFD);
    rd(2'd3, d); check("R7 mask readback", d, 8'h01);

    // R6 masking
    drive(1, 0, HOLD);
    rd(2'd1, d); check("R6 masked start", d, 8'h01);
    check("R6 irq on", {7'd0, irq}, 8'h01);
    drive(1, 1, HOLD);
    rd(2'd1, d); check("R6 stop masked off", d, 8'h01);
    wr(2'd2, 8'h01);
    check("R6 irq still off-mask stop", {7'd0, irq}, 8'h00);
    rd(2'd0, d); check("R6 raw stop remains", d, 8'h02);
    wr(2'd3, 8'h02);
    check("R6 irq stop", {7'd0, irq}, 8'h01);
    rd(2'd1, d); check("R6 masked stop", d, 8'h02);
    wr(2'd2, 8'h03);
    check("R6 irq cleared", {7'd0, irq}, 8'h00);

    // R8 glitch on SDA while SCL high
    @(negedge clk); sda = 1'b0;
    repeat (2) @(negedge clk); sda = 1'b1;
    repeat (HOLD) @(negedge clk);
    rd(2'd0, d); check("R8 glitch ignored", d, 8'h00);
    // R8 glitch on SCL while bus busy
    drive(1, 0, HOLD); wr(2'd2, 8'h03);
    drive(0, 0, HOLD); drive(0, 1, HOLD);
    @(negedge clk); scl = 1'b1;
    repeat (2) @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = 1'b0;
    repeat (HOLD) @(negedge clk);
    rd(2'd0, d); check("R8 scl glitch no stop", d, 8'h04);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule